// File: doc/BRIEF.md
# Prefix-Operand Accumulator Processor Core

This block is a compact multi-cycle processor with four 32-bit registers: a program counter, an accumulator A, a second register B and an operand register. It reads one 8-bit instruction per fetch from a byte-addressed instruction port. The high nibble of each instruction selects the operation and the low nibble supplies four operand bits. Wider constants are assembled first by chaining prefix and negative-prefix instructions into the operand register. The next ordinary instruction consumes that value and clears it.

The core reads and writes 32-bit data words through a separate synchronous data port whose address is a word index. It branches relative to the incremented program counter. A register-to-register operate group holds the jump-through-B, add and subtract operations, the supervisor call and the two channel operations. Channel input and output are forwarded to an external port. The core stalls there until the port reports completion. A supervisor call raises a one-cycle strobe with A and B on output ports, and the core then stops.

Top module: `pfx_acc_core`

## Requirements
- R1: While reset is held, the fetch address, svcA, svcB, halted, illegalOp, chanReq and dataWrEn are all 0. After reset is released, the first instruction is fetched from byte address 0.
- R2: Instructions are 8 bits: opcode in bits 7:4, operand nibble in bits 3:0. The effective operand is the operand register OR'd with the nibble. Opcode 0xE (prefix) stores the effective operand shifted left by 4. Opcode 0xF (negative prefix) stores its bitwise inverse shifted left by 4.
- R3: Every instruction other than 0xE and 0xF clears the operand register, so the instruction after it starts from a zero operand.
- R4: Opcode 0x0 loads A from the data word at the operand, 0x1 loads B from that word, and 0x2 stores A to that word. Data addresses are word indices.
- R5: Opcode 0x6 loads A and 0x7 loads B from the word at B plus the operand. Opcode 0x8 stores A to the word at B plus the operand.
- R6: Opcode 0x3 loads A with the operand and 0x4 loads B with the operand. Opcode 0x5 loads A with (address of the instruction + 1) plus the operand.
- R7: Opcode 0x9 continues execution at (address of the instruction + 1) plus the operand.
- R8: Opcode 0xA takes the same relative branch only if A is zero, and opcode 0xB only if A bit 31 is set. Otherwise execution continues at the next byte.
- R9: Opcode 0xD with sub-operation 0 jumps to the address held in B. Sub-operation 1 sets A = A + B and sub-operation 2 sets A = A - B, both modulo 2^32.
- R10: Opcode 0xD with sub-operation 3 drives svcStrobe high for exactly one cycle, with A on svcA and B on svcB. The core then stays halted, and its fetch address no longer changes.
- R11: Opcode 0xD sub-operation 4 (input, chanIsOut=0) and sub-operation 5 (output, chanIsOut=1) hold chanReq high until chanDone. During the request, chanSlot is B bits 1:0 and chanTxData is A. On an input, chanRxData is written into A when the request completes.
- R12: Opcode 0xC, and opcode 0xD with a sub-operation above 5, set illegalOp, halt the core and raise no svcStrobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instAddr | output | 32 | Byte address of the instruction being fetched |
| instData | input | 8 | Instruction byte, returned one cycle after instAddr |
| dataAddr | output | 32 | Word index for a data read or write |
| dataWrEn | output | 1 | Data write strobe |
| dataWrData | output | 32 | Word to store (A) |
| dataRdData | input | 32 | Read word, returned one cycle after dataAddr |
| chanReq | output | 1 | Channel transfer pending |
| chanIsOut | output | 1 | 1 for output, 0 for input |
| chanSlot | output | 2 | Channel slot selected by B |
| chanTxData | output | 32 | Word sent on output (A) |
| chanRxData | input | 32 | Word received on input |
| chanDone | input | 1 | Channel partner completes the transfer |
| svcStrobe | output | 1 | One-cycle supervisor call pulse |
| svcA | output | 32 | Current A value |
| svcB | output | 32 | Current B value |
| halted | output | 1 | Core has stopped |
| illegalOp | output | 1 | Stop was caused by an undefined instruction |

## Verification
A corrupted operand register becomes visible on the next constant load: A or B shows a wrong value, or a branch skips to the wrong byte. Each program therefore places illegal bytes on every wrongly taken path, so a bad branch decision raises illegalOp within two cycles. A wrong controller state appears as a missing or extra channel request, a write strobe in the wrong cycle, or a halt that never comes. The channel responder records the slot, direction, data and stall length of every transfer. A or B values that are wrong but produce no other symptom are caught at the final supervisor call, where both registers are compared on svcA and svcB.

// File: rtl/pfx_core_pkg.sv
package pfx_core_pkg;
  localparam int INSN_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [3:0] {
    OP_LDAM = 4'h0, OP_LDBM = 4'h1, OP_STAM = 4'h2, OP_LDAC = 4'h3,
    OP_LDBC = 4'h4, OP_LDAP = 4'h5, OP_LDAI = 4'h6, OP_LDBI = 4'h7,
    OP_STAI = 4'h8, OP_BR   = 4'h9, OP_BRZ  = 4'hA, OP_BRN  = 4'hB,
    OP_RSVD = 4'hC, OP_OPR  = 4'hD, OP_PFIX = 4'hE, OP_NFIX = 4'hF
  } opcode_e;

  localparam logic [3:0] SUB_JMPB = 4'h0;
  localparam logic [3:0] SUB_ADD  = 4'h1;
  localparam logic [3:0] SUB_SUB  = 4'h2;
  localparam logic [3:0] SUB_SVC  = 4'h3;
  localparam logic [3:0] SUB_IN   = 4'h4;
  localparam logic [3:0] SUB_OUT  = 4'h5;

  typedef enum logic [2:0] {A_CONST, A_PCREL, A_MEM, A_SUM, A_DIFF, A_CHAN} aSel_e;
  typedef enum logic [1:0] {PC_INC, PC_REL, PC_BREG} pcSel_e;
  typedef enum logic [1:0] {OR_HOLD, OR_CLEAR, OR_PFIX, OR_NFIX} orSel_e;

  typedef struct packed {
    logic   wrA;
    aSel_e  aSel;
    logic   wrB;
    logic   bFromMem;
    logic   wrPc;
    pcSel_e pcSel;
    orSel_e orSel;
    logic   addrIdx;
  } strobe_t;
endpackage

// File: rtl/pfx_core_dpath.sv
module pfx_core_dpath
  import pfx_core_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [NIB_W-1:0]    nibble,
  input  logic [DW-1:0]       memWord,
  input  logic [DW-1:0]       chanWord,
  output logic [DW-1:0]       pcQ,
  output logic [DW-1:0]       aQ,
  output logic [DW-1:0]       bQ,
  output logic [DW-1:0]       memAddr,
  output logic                aZero,
  output logic                aNeg
);
  logic [DW-1:0] oregQ;
  logic [DW-1:0] operand;
  logic [DW-1:0] pcInc;
  logic [DW-1:0] aNext;

  assign operand = oregQ | DW'(nibble);
  assign pcInc   = pcQ + DW'(1);
  assign memAddr = strb.addrIdx ? (bQ + operand) : operand;
  assign aZero   = (aQ == '0);
  assign aNeg    = aQ[DW-1];

  always_comb begin
    unique case (strb.aSel)
      A_CONST: aNext = operand;
      A_PCREL: aNext = pcInc + operand;
      A_MEM:   aNext = memWord;
      A_SUM:   aNext = aQ + bQ;
      A_DIFF:  aNext = aQ - bQ;
      A_CHAN:  aNext = chanWord;
      default: aNext = aQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= '0;
      aQ    <= '0;
      bQ    <= '0;
      oregQ <= '0;
    end else begin
      if (strb.wrPc) begin
        unique case (strb.pcSel)
          PC_REL:  pcQ <= pcInc + operand;
          PC_BREG: pcQ <= bQ;
          default: pcQ <= pcInc;
        endcase
      end
      if (strb.wrA) aQ <= aNext;
      if (strb.wrB) bQ <= strb.bFromMem ? memWord : operand;
      unique case (strb.orSel)
        OR_CLEAR: oregQ <= '0;
        OR_PFIX:  oregQ <= operand << NIB_W;
        OR_NFIX:  oregQ <= (~operand) << NIB_W;
        default:  oregQ <= oregQ;
      endcase
    end
  end
endmodule

// File: rtl/pfx_core_ctrl.sv
module pfx_core_ctrl
  import pfx_core_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [INSN_W-1:0] insn,
  input  logic              aZero,
  input  logic              aNeg,
  input  logic              chanDone,
  output strobe_t           strb,
  output logic              memWrEn,
  output logic              chanReq,
  output logic              chanIsOut,
  output logic              svcStrobe,
  output logic              halted,
  output logic              illegalOp
);
  typedef enum logic [2:0] {ST_FETCH, ST_EXEC, ST_LOAD, ST_CHAN, ST_HALT} state_e;

  state_e  stateQ, stateN;
  logic    loadBQ, loadBN;
  logic    outQ, outN;
  logic    illegalQ, illegalN;
  opcode_e opc;
  logic [NIB_W-1:0] sub;

  assign opc = opcode_e'(insn[INSN_W-1:NIB_W]);
  assign sub = insn[NIB_W-1:0];

  always_comb begin
    strb      = '0;
    strb.aSel = A_CONST;
    strb.pcSel = PC_INC;
    strb.orSel = OR_HOLD;
    stateN    = stateQ;
    loadBN    = loadBQ;
    outN      = outQ;
    illegalN  = illegalQ;
    memWrEn   = 1'b0;
    chanReq   = 1'b0;
    svcStrobe = 1'b0;
    unique case (stateQ)
      ST_FETCH: stateN = ST_EXEC;
      ST_EXEC: begin
        stateN     = ST_FETCH;
        strb.wrPc  = 1'b1;
        strb.orSel = OR_CLEAR;
        unique case (opc)
          OP_LDAM, OP_LDBM, OP_LDAI, OP_LDBI: begin
            strb.addrIdx = (opc == OP_LDAI) || (opc == OP_LDBI);
            loadBN       = (opc == OP_LDBM) || (opc == OP_LDBI);
            stateN       = ST_LOAD;
          end
          OP_STAM, OP_STAI: begin
            strb.addrIdx = (opc == OP_STAI);
            memWrEn      = 1'b1;
          end
          OP_LDAC: strb.wrA = 1'b1;
          OP_LDBC: strb.wrB = 1'b1;
          OP_LDAP: begin strb.wrA = 1'b1; strb.aSel = A_PCREL; end
          OP_BR:   strb.pcSel = PC_REL;
          OP_BRZ:  if (aZero) strb.pcSel = PC_REL;
          OP_BRN:  if (aNeg)  strb.pcSel = PC_REL;
          OP_PFIX: strb.orSel = OR_PFIX;
          OP_NFIX: strb.orSel = OR_NFIX;
          OP_OPR: begin
            unique case (sub)
              SUB_JMPB: strb.pcSel = PC_BREG;
              SUB_ADD:  begin strb.wrA = 1'b1; strb.aSel = A_SUM;  end
              SUB_SUB:  begin strb.wrA = 1'b1; strb.aSel = A_DIFF; end
              SUB_SVC:  begin svcStrobe = 1'b1; stateN = ST_HALT; end
              SUB_IN, SUB_OUT: begin
                outN   = (sub == SUB_OUT);
                stateN = ST_CHAN;
              end
              default: begin illegalN = 1'b1; stateN = ST_HALT; end
            endcase
          end
          default: begin illegalN = 1'b1; stateN = ST_HALT; end
        endcase
      end
      ST_LOAD: begin
        stateN = ST_FETCH;
        if (loadBQ) begin
          strb.wrB      = 1'b1;
          strb.bFromMem = 1'b1;
        end else begin
          strb.wrA  = 1'b1;
          strb.aSel = A_MEM;
        end
      end
      ST_CHAN: begin
        chanReq = 1'b1;
        if (chanDone) begin
          stateN = ST_FETCH;
          if (!outQ) begin
            strb.wrA  = 1'b1;
            strb.aSel = A_CHAN;
          end
        end
      end
      default: stateN = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_FETCH;
      loadBQ   <= 1'b0;
      outQ     <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      stateQ   <= stateN;
      loadBQ   <= loadBN;
      outQ     <= outN;
      illegalQ <= illegalN;
    end
  end

  assign chanIsOut = outQ;
  assign halted    = (stateQ == ST_HALT);
  assign illegalOp = illegalQ;

  assert_svc_halts_R10: assert property (@(posedge clk) disable iff (!rstN)
    svcStrobe |=> halted && !svcStrobe);
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);
  assert_chan_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    chanReq && !chanDone |=> chanReq && $stable(chanIsOut));
  assert_single_action_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWrEn, chanReq, svcStrobe}));
  assert_illegal_halts_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(illegalOp) |-> halted && !$past(svcStrobe));
endmodule

// File: rtl/pfx_acc_core.sv
module pfx_acc_core
  import pfx_core_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DW-1:0]     instAddr,
  input  logic [INSN_W-1:0] instData,
  output logic [DW-1:0]     dataAddr,
  output logic              dataWrEn,
  output logic [DW-1:0]     dataWrData,
  input  logic [DW-1:0]     dataRdData,
  output logic              chanReq,
  output logic              chanIsOut,
  output logic [SLOT_W-1:0] chanSlot,
  output logic [DW-1:0]     chanTxData,
  input  logic [DW-1:0]     chanRxData,
  input  logic              chanDone,
  output logic              svcStrobe,
  output logic [DW-1:0]     svcA,
  output logic [DW-1:0]     svcB,
  output logic              halted,
  output logic              illegalOp
);
  strobe_t       strb;
  logic          aZero, aNeg;
  logic [DW-1:0] aQ, bQ;

  pfx_core_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .insn(instData), .aZero(aZero), .aNeg(aNeg),
    .chanDone(chanDone), .strb(strb), .memWrEn(dataWrEn), .chanReq(chanReq),
    .chanIsOut(chanIsOut), .svcStrobe(svcStrobe), .halted(halted),
    .illegalOp(illegalOp)
  );

  pfx_core_dpath #(.DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .nibble(instData[NIB_W-1:0]),
    .memWord(dataRdData), .chanWord(chanRxData), .pcQ(instAddr), .aQ(aQ),
    .bQ(bQ), .memAddr(dataAddr), .aZero(aZero), .aNeg(aNeg)
  );

  assign dataWrData = aQ;
  assign chanTxData = aQ;
  assign chanSlot   = bQ[SLOT_W-1:0];
  assign svcA       = aQ;
  assign svcB       = bQ;
endmodule

// File: tb/pfx_acc_core_tb.sv
`timescale 1ns/1ps
module pfx_acc_core_tb_top;
  localparam int CH_DELAY = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instAddr;
  logic [7:0]  instData;
  logic [31:0] dataAddr;
  logic        dataWrEn;
  logic [31:0] dataWrData;
  logic [31:0] dataRdData;
  logic        chanReq, chanIsOut;
  logic [1:0]  chanSlot;
  logic [31:0] chanTxData;
  logic [31:0] chanRxData = 32'hDEADBEEF;
  logic        chanDone;
  logic        svcStrobe;
  logic [31:0] svcA, svcB;
  logic        halted, illegalOp;

  logic [7:0]  imem [256];
  logic [31:0] dmem [64];

  int testsRun = 0;
  int testsFailed = 0;
  int svcCount;
  logic [31:0] svcCapA, svcCapB;
  int chanCount;
  int waitCnt;
  logic [1:0]  logSlot [4];
  logic        logOut  [4];
  logic [31:0] logTx   [4];
  int          logWait [4];

  always #10 clk = ~clk;

  pfx_acc_core dut_i (
    .clk(clk), .rstN(rstN), .instAddr(instAddr), .instData(instData),
    .dataAddr(dataAddr), .dataWrEn(dataWrEn), .dataWrData(dataWrData),
    .dataRdData(dataRdData), .chanReq(chanReq), .chanIsOut(chanIsOut),
    .chanSlot(chanSlot), .chanTxData(chanTxData), .chanRxData(chanRxData),
    .chanDone(chanDone), .svcStrobe(svcStrobe), .svcA(svcA), .svcB(svcB),
    .halted(halted), .illegalOp(illegalOp)
  );

  always @(posedge clk) begin
    instData   <= imem[instAddr[7:0]];
    dataRdData <= dmem[dataAddr[5:0]];
    if (dataWrEn) dmem[dataAddr[5:0]] <= dataWrData;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      svcCount <= 0; svcCapA <= '0; svcCapB <= '0;
    end else if (svcStrobe) begin
      svcCount <= svcCount + 1; svcCapA <= svcA; svcCapB <= svcB;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      chanDone <= 1'b0; waitCnt <= 0; chanCount <= 0;
    end else if (chanReq && chanDone) begin
      chanDone <= 1'b0;
      waitCnt  <= 0;
      if (chanCount < 4) begin
        logSlot[chanCount] <= chanSlot;
        logOut[chanCount]  <= chanIsOut;
        logTx[chanCount]   <= chanTxData;
        logWait[chanCount] <= waitCnt;
      end
      chanCount <= chanCount + 1;
    end else if (chanReq) begin
      waitCnt <= waitCnt + 1;
      if (waitCnt == CH_DELAY - 1) chanDone <= 1'b1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) imem[i] = 8'hC0;
    for (int i = 0; i < 64; i++) dmem[i] = '0;
  endtask

  task automatic runProg();
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
    chk("R10", "program reached halt", {31'd0, halted}, 32'd1);
  endtask

  task automatic testReset();
    clearMem();
    imem[0] = 8'hD3;
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "instAddr in reset", instAddr, 32'd0);
    chk("R1", "flags in reset", {28'd0, halted, illegalOp, chanReq, dataWrEn}, 32'd0);
    chk("R1", "A/B in reset", svcA | svcB, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "first fetch address", instAddr, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic testPrefix();
    clearMem();
    imem[0] = 8'hE1; imem[1] = 8'hE2; imem[2] = 8'h33;
    imem[3] = 8'hF0; imem[4] = 8'h45; imem[5] = 8'hD3;
    runProg();
    chk("R2", "prefix chain into A", svcA, 32'h0000_0123);
    chk("R2", "negative prefix into B", svcB, 32'hFFFF_FFF5);
  endtask

  task automatic testClear();
    clearMem();
    imem[0] = 8'hE1; imem[1] = 8'h32; imem[2] = 8'h43; imem[3] = 8'hD3;
    runProg();
    chk("R3", "prefixed A", svcA, 32'h12);
    chk("R3", "operand cleared for B", svcB, 32'h3);
  endtask

  task automatic testDirect();
    clearMem();
    dmem[5] = 32'hCAFE0001; dmem[6] = 32'd7;
    imem[0] = 8'h05; imem[1] = 8'h16; imem[2] = 8'h29; imem[3] = 8'hD3;
    runProg();
    chk("R4", "direct load A", svcA, 32'hCAFE0001);
    chk("R4", "direct load B", svcB, 32'd7);
    chk("R4", "direct store", dmem[9], 32'hCAFE0001);
  endtask

  task automatic testIndexed();
    clearMem();
    dmem[11] = 32'h77; dmem[12] = 32'h55;
    imem[0] = 8'h4A; imem[1] = 8'h62; imem[2] = 8'h83; imem[3] = 8'h71; imem[4] = 8'hD3;
    runProg();
    chk("R5", "indexed load A", svcA, 32'h55);
    chk("R5", "indexed store", dmem[13], 32'h55);
    chk("R5", "indexed load B", svcB, 32'h77);
  endtask

  task automatic testLdapBr();
    clearMem();
    imem[0] = 8'h97; imem[8] = 8'h51; imem[9] = 8'hD3;
    runProg();
    chk("R7", "branch skipped bytes", {31'd0, illegalOp}, 32'd0);
    chk("R6", "pc-relative A", svcA, 32'd10);
  endtask

  task automatic testCond();
    clearMem();
    imem[0]  = 8'h30; imem[1]  = 8'hA1; imem[3]  = 8'h31; imem[4]  = 8'hA1;
    imem[5]  = 8'h42; imem[6]  = 8'hD2; imem[7]  = 8'hB1; imem[9]  = 8'h45;
    imem[10] = 8'hD1; imem[11] = 8'hB1; imem[12] = 8'hD3;
    runProg();
    chk("R8", "conditional paths legal", {31'd0, illegalOp}, 32'd0);
    chk("R9", "sub then add result", svcA, 32'd4);
    chk("R8", "B after taken BRN", svcB, 32'd5);
  endtask

  task automatic testJmpB();
    clearMem();
    imem[0] = 8'h46; imem[1] = 8'hD0; imem[6] = 8'h37; imem[7] = 8'hD3;
    runProg();
    chk("R9", "jump via B legal", {31'd0, illegalOp}, 32'd0);
    chk("R9", "jump via B target", svcA, 32'd7);
  endtask

  task automatic testChan();
    clearMem();
    imem[0] = 8'h42; imem[1] = 8'hE4; imem[2] = 8'h31; imem[3] = 8'hD5;
    imem[4] = 8'h41; imem[5] = 8'hD4; imem[6] = 8'hD3;
    runProg();
    chk("R11", "transfer count", chanCount, 32'd2);
    chk("R11", "out slot", {30'd0, logSlot[0]}, 32'd2);
    chk("R11", "out direction", {31'd0, logOut[0]}, 32'd1);
    chk("R11", "out data", logTx[0], 32'h41);
    chk("R11", "out stalled", {31'd0, logWait[0] >= CH_DELAY}, 32'd1);
    chk("R11", "in slot", {30'd0, logSlot[1]}, 32'd1);
    chk("R11", "in direction", {31'd0, logOut[1]}, 32'd0);
    chk("R11", "in data to A", svcA, 32'hDEADBEEF);
  endtask

  task automatic testSvc();
    logic [31:0] addrAtHalt;
    clearMem();
    imem[0] = 8'h39; imem[1] = 8'h4C; imem[2] = 8'hD3;
    runProg();
    addrAtHalt = instAddr;
    repeat (6) @(negedge clk);
    chk("R10", "strobe count", svcCount, 32'd1);
    chk("R10", "A at strobe", svcCapA, 32'd9);
    chk("R10", "B at strobe", svcCapB, 32'd12);
    chk("R10", "stays halted", {31'd0, halted}, 32'd1);
    chk("R10", "fetch frozen", instAddr, addrAtHalt);
  endtask

  task automatic testIllegal();
    clearMem();
    imem[0] = 8'h31; imem[1] = 8'hC0; imem[2] = 8'hD3;
    runProg();
    chk("R12", "opcode C flag", {31'd0, illegalOp}, 32'd1);
    chk("R12", "opcode C no svc", svcCount, 32'd0);
    clearMem();
    imem[0] = 8'hD6; imem[1] = 8'hD3;
    runProg();
    chk("R12", "bad sub-op flag", {31'd0, illegalOp}, 32'd1);
    chk("R12", "bad sub-op no svc", svcCount, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    clearMem();
    testReset();
    testPrefix();
    testClear();
    testDirect();
    testIndexed();
    testLdapBr();
    testCond();
    testJmpB();
    testChan();
    testSvc();
    testIllegal();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule